// File: doc/BRIEF.md
# DC Breaker Trip Sequencer

This block is the digital controller of a mechanically switched DC circuit breaker with counter-current injection. It turns a protection fault indication into timed commands for the three switches of the breaker: the main interrupter, the residual-current breaker and the injection switch that fires the pre-charged resonant branch. Every delay is a count of clock cycles taken from an input port. At 1 MHz, a 2 ms relay delay is 2000 cycles and an 8 ms switch delay is 8000 cycles.

A fault seen while the block is idle starts a relay-delay timer. When that timer expires, the trip is held in a set-reset latch, and the latch then runs three independent switch timers. The main interrupter and the residual breaker are commanded open when their own timers expire. The injection switch is commanded closed when its timer expires, but only in full mode. In reduced mode the injection path is left out and its command stays open. The latch stays set, so the block performs exactly one open operation. Only a synchronous reset returns it to rest. It has no reclosing.

Top module: `brk_trip_seq`

## Requirements
- R1: After a synchronous reset cycle, main_open_o=0 and resid_open_o=0 (both switches commanded closed), inj_close_o=0 (injection switch commanded open), busy_o=0 and done_o=0.
- R2: A fault_i high sampled at edge E while the block is idle sets busy_o at E. The trip latches at edge E+D, where D is relay_dly_i and a value of 0 counts as 1.
- R3: Once a relay delay has started, further fault_i activity has no effect until reset. This includes chattering, pulses and a level held after done.
- R4: main_open_o rises at edge E+D+Dm, where Dm is main_dly_i (0 counts as 1), and then stays high.
- R5: resid_open_o rises at edge E+D+Dr, where Dr is resid_dly_i (0 counts as 1), and then stays high.
- R6: In full mode (mode_full_i=1 at the latching edge), inj_close_o rises at edge E+D+Di, where Di is inj_dly_i (0 counts as 1).
- R7: In reduced mode (mode_full_i=0 at the latching edge), inj_close_o stays 0 for the whole sequence.
- R8: done_o rises at the edge on which the last enabled switch timer expires. The injection timer is not counted in reduced mode. done_o then stays high, and busy_o is low whenever done_o is high.
- R9: A synchronous reset at any point in a sequence clears the latch and returns all outputs to the R1 state. A fault after the reset starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_i | input | 1 | Protection fault indication |
| mode_full_i | input | 1 | 1 = full mode with injection, 0 = reduced mode |
| relay_dly_i | input | CNT_W | Relay delay in cycles |
| main_dly_i | input | CNT_W | Main interrupter delay after the trip, in cycles |
| resid_dly_i | input | CNT_W | Residual breaker delay after the trip, in cycles |
| inj_dly_i | input | CNT_W | Injection switch delay after the trip, in cycles |
| main_open_o | output | 1 | 1 = open the main interrupter |
| resid_open_o | output | 1 | 1 = open the residual breaker |
| inj_close_o | output | 1 | 1 = close the injection switch |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All enabled switch delays have expired |

## Verification
Some properties hold on every cycle, and the embedded assertions check those:
- the trip latch never falls without reset;
- a pending relay delay never coexists with a set latch;
- no switch command fires before its timer is enabled by the latch;
- the injection command never appears in reduced mode;
- done_o implies both breakers are open, is sticky, and never overlaps busy_o.

The exact edge on which each command changes depends on the programmed counts, and only the bench scenarios can show it. The same holds for the treatment of zero counts, immunity to a chattering fault input, and the recovery after a reset in the middle of a sequence. The bench recomputes each of these cycle by cycle from the delay values.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  localparam int NUM_SW    = 3;
  localparam int IDX_MAIN  = 0;
  localparam int IDX_RESID = 1;
  localparam int IDX_INJ   = 2;

  // Effective limit: a programmed zero behaves as one cycle.
  function automatic logic [31:0] eff_limit(input logic [31:0] lim);
    return (lim == 32'd0) ? 32'd1 : lim;
  endfunction

  // True when the count about to be reached meets the limit.
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= eff_limit(lim);
  endfunction
endpackage

// File: rtl/brk_relay_delay.sv
module brk_relay_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_i,
  input  logic             blocked_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             pending_o,
  output logic             trip_set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             hit;

  assign hit        = brk_seq_pkg::limit_hit(32'(cnt_q), 32'(dly_i));
  assign trip_set_o = pend_q & hit;
  assign pending_o  = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (hit) pend_q <= 1'b0;
      else     cnt_q  <= cnt_q + 1'b1;
    end else if (fault_i && !blocked_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  // R3
  no_relay_after_trip_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !blocked_i);
endmodule

// File: rtl/brk_trip_latch.sv
module brk_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic mode_full_i,
  output logic latched_o,
  output logic mode_full_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latched_o   <= 1'b0;
      mode_full_o <= 1'b0;
    end else if (set_i && !latched_o) begin
      latched_o   <= 1'b1;
      mode_full_o <= mode_full_i;
    end
  end

  // R3
  latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    latched_o |=> latched_o);
  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    latched_o |=> $stable(mode_full_o));
endmodule

// File: rtl/brk_switch_timer.sv
module brk_switch_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = brk_seq_pkg::limit_hit(32'(cnt_q), 32'(dly_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (run_i && !expired_o) begin
      if (hit) expired_o <= 1'b1;
      else     cnt_q     <= cnt_q + 1'b1;
    end
  end

  // R4
  expire_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    expired_o |-> run_i);
endmodule

// File: rtl/brk_trip_seq.sv
module brk_trip_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_i,
  input  logic             mode_full_i,
  input  logic [CNT_W-1:0] relay_dly_i,
  input  logic [CNT_W-1:0] main_dly_i,
  input  logic [CNT_W-1:0] resid_dly_i,
  input  logic [CNT_W-1:0] inj_dly_i,
  output logic             main_open_o,
  output logic             resid_open_o,
  output logic             inj_close_o,
  output logic             busy_o,
  output logic             done_o
);
  import brk_seq_pkg::*;

  logic                 relay_pending;
  logic                 trip_set;
  logic                 trip_latched;
  logic                 mode_full_q;
  logic [NUM_SW-1:0]    sw_run;
  logic [NUM_SW-1:0]    sw_expired;
  logic [NUM_SW-1:0]    sw_needed;
  logic [CNT_W-1:0]     sw_dly [NUM_SW];

  assign sw_dly[IDX_MAIN]  = main_dly_i;
  assign sw_dly[IDX_RESID] = resid_dly_i;
  assign sw_dly[IDX_INJ]   = inj_dly_i;

  brk_relay_delay #(.CNT_W(CNT_W)) relay_i (
    .clk        (clk),
    .rst        (rst),
    .fault_i    (fault_i),
    .blocked_i  (trip_latched),
    .dly_i      (relay_dly_i),
    .pending_o  (relay_pending),
    .trip_set_o (trip_set)
  );

  brk_trip_latch latch_i (
    .clk         (clk),
    .rst         (rst),
    .set_i       (trip_set),
    .mode_full_i (mode_full_i),
    .latched_o   (trip_latched),
    .mode_full_o (mode_full_q)
  );

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    if (g == IDX_INJ) begin : g_gated
      assign sw_needed[g] = mode_full_q;
    end else begin : g_plain
      assign sw_needed[g] = 1'b1;
    end
    assign sw_run[g] = trip_latched & sw_needed[g];

    brk_switch_timer #(.CNT_W(CNT_W)) timer_i (
      .clk       (clk),
      .rst       (rst),
      .run_i     (sw_run[g]),
      .dly_i     (sw_dly[g]),
      .expired_o (sw_expired[g])
    );
  end

  assign main_open_o  = sw_expired[IDX_MAIN];
  assign resid_open_o = sw_expired[IDX_RESID];
  assign inj_close_o  = sw_expired[IDX_INJ];
  assign done_o       = trip_latched & (&(sw_expired | ~sw_needed));
  assign busy_o       = relay_pending | (trip_latched & ~done_o);

  // R7
  no_inj_reduced_chk: assert property (@(posedge clk) disable iff (rst)
    inj_close_o |-> mode_full_q);
  // R8
  done_opens_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (main_open_o && resid_open_o));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  // R2
  latch_after_relay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_latched) |-> $past(relay_pending));
endmodule

// File: tb/brk_trip_seq_tb.sv
`timescale 1ns/1ps
module brk_trip_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault_i = 1'b0;
  logic mode_full_i = 1'b1;
  logic [CNT_W-1:0] relay_dly_i = '0;
  logic [CNT_W-1:0] main_dly_i  = '0;
  logic [CNT_W-1:0] resid_dly_i = '0;
  logic [CNT_W-1:0] inj_dly_i   = '0;
  logic main_open_o, resid_open_o, inj_close_o, busy_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  brk_trip_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .fault_i(fault_i), .mode_full_i(mode_full_i),
    .relay_dly_i(relay_dly_i), .main_dly_i(main_dly_i),
    .resid_dly_i(resid_dly_i), .inj_dly_i(inj_dly_i),
    .main_open_o(main_open_o), .resid_open_o(resid_open_o),
    .inj_close_o(inj_close_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check_rest(input string req);
    check(req, "main_open_o",  main_open_o,  1'b0);
    check(req, "resid_open_o", resid_open_o, 1'b0);
    check(req, "inj_close_o",  inj_close_o,  1'b0);
    check(req, "busy_o",       busy_o,       1'b0);
    check(req, "done_o",       done_o,       1'b0);
  endtask

  // R1 / R9: reset for one edge, check rest state
  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; fault_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_rest(req);
  endtask

  // Runs one sequence; expected outputs derived per edge from R2..R8.
  // style: 0 = one-cycle pulse, 1 = chatter every cycle, 2 = held high
  task automatic run_seq(input int d, input int dm, input int dr, input int di,
                         input bit full, input int style, input int n_edges);
    int b, t_done, tail;
    logic e_main, e_resid, e_inj, e_done, e_busy;
    @(negedge clk);
    relay_dly_i = CNT_W'(d); main_dly_i = CNT_W'(dm);
    resid_dly_i = CNT_W'(dr); inj_dly_i = CNT_W'(di);
    mode_full_i = full;
    fault_i = 1'b1;
    b = 1 + eff(d);
    tail = full ? eff(di) : 0;
    t_done = b + ((eff(dm) > eff(dr)) ? eff(dm) : eff(dr));
    if (b + tail > t_done) t_done = b + tail;
    for (int k = 1; k <= n_edges; k++) begin
      @(posedge clk);
      @(negedge clk);
      e_main  = (k >= b + eff(dm));
      e_resid = (k >= b + eff(dr));
      e_inj   = full && (k >= b + eff(di));
      e_done  = (k >= t_done);
      e_busy  = !e_done;
      check("R4", "main_open_o",  main_open_o,  e_main);
      check("R5", "resid_open_o", resid_open_o, e_resid);
      check(full ? "R6" : "R7", "inj_close_o", inj_close_o, e_inj);
      check("R8", "done_o", done_o, e_done);
      check("R2", "busy_o", busy_o, e_busy);
      // R3: fault activity after the first sample must not matter
      case (style)
        0: fault_i = 1'b0;
        1: fault_i = ~fault_i;
        default: fault_i = 1'b1;
      endcase
      // flip mode after latching: must not affect the frozen choice (R7)
      if (k > b) mode_full_i = ~full;
    end
    fault_i = 1'b0;
  endtask

  task automatic test_reset_state();
    do_reset("R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_rest("R1");
  endtask

  task automatic test_full_pulse();
    do_reset("R1");
    run_seq(3, 5, 7, 4, 1'b1, 0, 16);
  endtask

  task automatic test_full_chatter();
    do_reset("R1");
    run_seq(4, 6, 2, 9, 1'b1, 1, 22);
  endtask

  task automatic test_reduced_held();
    do_reset("R1");
    run_seq(2, 3, 4, 12, 1'b0, 2, 24);
  endtask

  task automatic test_zero_delays();
    do_reset("R1");
    run_seq(0, 0, 0, 0, 1'b1, 1, 6);
  endtask

  task automatic test_no_fault();
    do_reset("R1");
    repeat (10) @(posedge clk);
    @(negedge clk);
    check_rest("R2");
  endtask

  task automatic test_mid_reset();
    do_reset("R1");
    run_seq(2, 4, 9, 6, 1'b1, 0, 8);
    do_reset("R9");
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_rest("R9");
    run_seq(1, 2, 3, 2, 1'b1, 0, 8);
  endtask

  initial begin
    test_reset_state();
    test_full_pulse();
    test_full_chatter();
    test_reduced_held();
    test_zero_delays();
    test_no_fault();
    test_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule